// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is a serial-bus target that gives an external controller read and write access to a small bank of eight-bit configuration registers. It samples the SCL and SDA wires with the system clock and recognises start, repeated start and stop conditions. It answers one 7-bit device address. The upper four bits of that address are fixed to binary 1001, and the lower three come from strap pins. It pulls SDA low through an open-drain enable and never drives SCL.

A register pointer is loaded by the second byte of a write transaction and holds its value until the next reset or the next pointer load. A later read transaction therefore returns the register at that pointer without sending the pointer again. Each transaction moves one data byte. The register contents are presented in parallel on a flat output bus so that the surrounding logic can use them as live configuration. The whole interface responds only while the mode input is high.

Top module: `i2c_cfg_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal {4'b1001, addr_pins}. With pins 011 this is 0x4B. On a mismatch it acknowledges nothing and changes nothing until the next start condition.
- R2: A write transaction is start, address with R/W=0, register pointer, data, then stop or repeated start. The target acknowledges each of the three bytes. The data byte lands in the register at the pointer and appears on cfg_flat[8*p+7:8*p]. All bytes are sent MSB first.
- R3: A pointer load followed by a repeated start and an address with R/W=1 makes the target shift out, MSB first, the eight bits of the register at the pointer.
- R4: The pointer persists across stop conditions and repeated starts. A read transaction that sends no pointer returns the register last addressed.
- R5: Pointer values at or above NUM_REGS read as 0x00. Writes to them are acknowledged and change no register.
- R6: SDA is only ever pulled low. The pull starts only while SCL is low, and it is released after the controller's acknowledge bit of a read byte.
- R7: While mode_en is 0 the target never pulls SDA and writes no register.
- R8: A stop or start condition at any point returns the target to idle and releases SDA. A write cut off before its data byte is complete leaves every register unchanged.
- R9: After reset every register and the pointer are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Enables the serial interface when high |
| addr_pins | input | 3 | Strapped low bits of the device address |
| scl_i | input | 1 | Sampled serial clock wire |
| sda_i | input | 1 | Sampled serial data wire |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| cfg_flat | output | NUM_REGS*8 | All register contents, register p at bits 8p+7..8p |

## Verification
The bench builds the block with NUM_REGS=5 and two synchronizer stages. This leaves three of the eight pointer values unimplemented, so every address in the pointer range that matters falls into one of the two branches. Addresses are probed for all eight strap values against all eight low-bit candidates, which makes the match decision exhaustive. Every pointer from 0 to 7 is written and read back. The bench also covers pointer persistence, transfers aborted by stop and by start, and operation with the mode pin low.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [3:0] DEV_PREFIX = 4'b1001;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RDAT_ACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw;
  logic [1:0] cur;
  logic [1:0] old;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= {pipe_q[STAGES-1:0], raw[g]};
    end
    assign cur[g] = pipe_q[STAGES-1];
    assign old[g] = pipe_q[STAGES];
  end

  assign scl_s     = cur[0];
  assign sda_s     = cur[1];
  assign scl_rise  = cur[0] & ~old[0];
  assign scl_fall  = ~cur[0] & old[0];
  assign start_det = cur[0] & old[0] & old[1] & ~cur[1];
  assign stop_det  = cur[0] & old[0] & ~old[1] & cur[1];
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [2:0]        pins,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_drive,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] ptr
);
  tgt_state_e        state_q, state_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic [BYTE_W-1:0] ptr_q, ptr_d;
  logic              rw_q, rw_d;
  logic              drive_q, drive_d;
  logic              rx_state;

  assign rx_state = (state_q == ST_DEV) || (state_q == ST_REG) || (state_q == ST_WDAT);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    drive_d = drive_q;
    wr_en   = 1'b0;
    if (!enable) begin
      state_d = ST_IDLE;
      drive_d = 1'b0;
    end else if (start_det) begin
      state_d = ST_DEV;
      cnt_d   = 4'd0;
      drive_d = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      drive_d = 1'b0;
    end else if (rx_state) begin
      if (scl_rise && cnt_q != 4'd8) begin
        shift_d = {shift_q[BYTE_W-2:0], sda_s};
        cnt_d   = cnt_q + 4'd1;
      end else if (scl_fall && cnt_q == 4'd8) begin
        cnt_d = 4'd0;
        unique case (state_q)
          ST_DEV: begin
            if (shift_q[BYTE_W-1:1] == {DEV_PREFIX, pins}) begin
              rw_d    = shift_q[0];
              state_d = ST_DEV_ACK;
              drive_d = 1'b1;
            end else begin
              state_d = ST_SKIP;
            end
          end
          ST_REG: begin
            ptr_d   = shift_q;
            state_d = ST_REG_ACK;
            drive_d = 1'b1;
          end
          default: begin
            wr_en   = 1'b1;
            state_d = ST_WDAT_ACK;
            drive_d = 1'b1;
          end
        endcase
      end
    end else if (scl_fall) begin
      unique case (state_q)
        ST_DEV_ACK: begin
          if (rw_q) begin
            state_d = ST_RDAT;
            shift_d = rd_data;
            cnt_d   = 4'd0;
            drive_d = ~rd_data[BYTE_W-1];
          end else begin
            state_d = ST_REG;
            drive_d = 1'b0;
          end
        end
        ST_REG_ACK: begin
          state_d = ST_WDAT;
          drive_d = 1'b0;
        end
        ST_WDAT_ACK, ST_RDAT_ACK: begin
          state_d = ST_SKIP;
          drive_d = 1'b0;
        end
        ST_RDAT: begin
          if (cnt_q == 4'd7) begin
            state_d = ST_RDAT_ACK;
            drive_d = 1'b0;
          end else begin
            shift_d = {shift_q[BYTE_W-2:0], 1'b0};
            cnt_d   = cnt_q + 4'd1;
            drive_d = ~shift_q[BYTE_W-2];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      ptr_q   <= ptr_d;
      rw_q    <= rw_d;
      drive_q <= drive_d;
    end
  end

  assign sda_drive = drive_q;
  assign wr_data   = shift_q;
  assign ptr       = ptr_q;
endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs
  import i2c_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [BYTE_W-1:0]          addr,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [BYTE_W-1:0]          rd_data,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_flat
);
  logic [BYTE_W-1:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = wr_en && (addr == BYTE_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[i] <= '0;
      else if (hit) regs_q[i] <= wr_data;
    end
    assign cfg_flat[i*BYTE_W +: BYTE_W] = regs_q[i];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == BYTE_W'(i)) rd_data = regs_q[i];
    end
  end
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
  import i2c_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode_en,
  input  logic [2:0]                 addr_pins,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_flat
);
  logic [1:0]        rst_pipe_q;
  logic              rst_int;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data, ptr, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int = rst_pipe_q[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_target_fsm u_fsm (
    .clk(clk), .rst_n(rst_int), .enable(mode_en), .pins(addr_pins),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
    .sda_drive(sda_oe), .wr_en(wr_en), .wr_data(wr_data), .ptr(ptr)
  );

  i2c_cfg_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_int), .wr_en(wr_en), .addr(ptr),
    .wr_data(wr_data), .rd_data(rd_data), .cfg_flat(cfg_flat)
  );
endmodule

// File: rtl/i2c_cfg_target_chk.sv
module i2c_cfg_target_chk #(
  parameter int unsigned CFG_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_en,
  input logic             scl_s,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_oe,
  input logic             wr_en,
  input logic [CFG_W-1:0] cfg_flat
);
  // R7: disabled interface releases SDA
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !sda_oe);

  // R7: no register write while disabled
  a_r7_no_write_off: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> mode_en);

  // R6: a pull on SDA begins only after SCL was seen low
  a_r6_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && $rose(sda_oe)) |-> !$past(scl_s));

  // R8: bus conditions release SDA
  a_r8_release_on_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !sda_oe);

  // R2: register contents move only on a write strobe
  a_r2_cfg_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(cfg_flat));
endmodule

bind i2c_cfg_target i2c_cfg_target_chk #(.CFG_W(NUM_REGS*8)) u_chk (
  .clk(clk), .rst_n(rst_int), .mode_en(mode_en), .scl_s(scl_s),
  .start_det(start_det), .stop_det(stop_det), .sda_oe(sda_oe),
  .wr_en(wr_en), .cfg_flat(cfg_flat)
);

// File: tb/tb_i2c_cfg_target.sv
module tb_i2c_cfg_target;
  localparam int NREG = 5;
  localparam int QTR  = 10;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            mode_en;
  logic [2:0]      pins;
  logic            scl_m, sda_m;
  logic            sda_oe;
  logic [NREG*8-1:0] cfg;
  logic            sda_bus;
  logic [7:0]      model [8];
  int              checks = 0;
  int              failures = 0;
  bit              done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_cfg_target #(.NUM_REGS(NREG), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .addr_pins(pins),
    .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe), .cfg_flat(cfg)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic q(input int n = 1);
    repeat (n * QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(2); scl_m = 1'b0; q();
    end
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_bus; q(); scl_m = 1'b0; q();
  endtask

  task automatic rbyte(output logic [7:0] b, input bit nack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1'b1; q(); b[i] = sda_bus; q(); scl_m = 1'b0;
    end
    q(); sda_m = nack; q(); scl_m = 1'b1; q(2); scl_m = 1'b0; q(); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev(input logic [2:0] p, input bit rd);
    return {4'b1001, p, rd};
  endfunction

  function automatic logic [7:0] creg(input int a);
    return cfg[a*8 +: 8];
  endfunction

  task automatic write_reg(input int a, input logic [7:0] d, input bit exp_ack, input string tag);
    bit ack;
    bus_start();
    wbyte(dev(pins, 1'b0), ack); chk(ack == exp_ack, tag, ack, exp_ack);
    wbyte(8'(a), ack);           chk(ack == exp_ack, tag, ack, exp_ack);
    wbyte(d, ack);               chk(ack == exp_ack, tag, ack, exp_ack);
    bus_stop();
  endtask

  task automatic read_reg(input int a, input logic [7:0] exp, input string tag);
    bit ack;
    logic [7:0] v;
    bus_start();
    wbyte(dev(pins, 1'b0), ack);
    wbyte(8'(a), ack);
    bus_start();
    wbyte(dev(pins, 1'b1), ack); chk(ack, "R3 read address ack", ack, 1);
    rbyte(v, 1'b0);
    chk(v == exp, tag, v, exp);
    chk(!sda_oe, "R6 released after controller ack", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v;
    logic [7:0] d;
    rst_n = 1'b0; mode_en = 1'b1; pins = 3'b011; scl_m = 1'b1; sda_m = 1'b1;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R9: reset state
    chk(cfg == '0, "R9 registers zero after reset", int'(cfg[31:0]), 0);
    chk(!sda_oe, "R9 SDA released after reset", sda_oe, 0);
    bus_start();
    wbyte(8'h97, ack); chk(ack, "R1 address 0x4B read ack", ack, 1);
    rbyte(v, 1'b1); chk(v == 8'h00, "R9 pointer zero after reset", v, 0);
    bus_stop();

    // R1: exhaustive strap versus low-bit sweep
    for (int p = 0; p < 8; p++) begin
      pins = 3'(p);
      for (int c = 0; c < 8; c++) begin
        bus_start();
        wbyte(dev(3'(c), 1'b0), ack);
        chk(ack == (c == p), "R1 address match", ack, int'(c == p));
        bus_stop();
      end
    end
    pins = 3'b011;

    // R1: wrong prefix is ignored for the rest of the transaction
    bus_start();
    wbyte({7'h5B, 1'b0}, ack); chk(!ack, "R1 wrong prefix nack", ack, 0);
    wbyte(8'h01, ack);         chk(!ack, "R1 ignored pointer byte", ack, 0);
    wbyte(8'hEE, ack);         chk(!ack, "R1 ignored data byte", ack, 0);
    bus_stop();
    chk(creg(1) == 8'h00, "R1 ignored write leaves register", creg(1), 0);

    // R2, R5: write every pointer value
    for (int a = 0; a < 8; a++) begin
      d = 8'((a * 8'h23) + 8'h1C);
      write_reg(a, d, 1'b1, (a < NREG) ? "R2 write ack" : "R5 unimplemented write ack");
      if (a < NREG) model[a] = d;
      for (int r = 0; r < NREG; r++)
        chk(creg(r) == model[r], "R2 R5 register contents", creg(r), model[r]);
    end

    // R3, R5: read every pointer value
    for (int a = 0; a < 8; a++)
      read_reg(a, (a < NREG) ? model[a] : 8'h00,
               (a < NREG) ? "R3 read data" : "R5 unimplemented reads zero");

    // R4: pointer persists across stop and repeated start
    bus_start();
    wbyte(dev(pins, 1'b0), ack); wbyte(8'h02, ack);
    bus_stop();
    bus_start();
    wbyte(dev(pins, 1'b1), ack); rbyte(v, 1'b0);
    chk(v == model[2], "R4 read after stop uses kept pointer", v, model[2]);
    bus_start();
    wbyte(dev(pins, 1'b1), ack); rbyte(v, 1'b1);
    chk(v == model[2], "R4 repeated start re-reads", v, model[2]);
    bus_stop();

    // R8: abort a write by stop in mid data byte
    bus_start();
    wbyte(dev(pins, 1'b0), ack); wbyte(8'h01, ack);
    send_bits(8'h00, 4);
    bus_stop();
    chk(creg(1) == model[1], "R8 stop abort keeps register", creg(1), model[1]);
    chk(!sda_oe, "R8 SDA released after abort", sda_oe, 0);

    // R8: abort by start, then read with the loaded pointer
    bus_start();
    wbyte(dev(pins, 1'b0), ack); wbyte(8'h03, ack);
    send_bits(8'hFF, 5);
    bus_start();
    wbyte(dev(pins, 1'b1), ack); chk(ack, "R8 new start accepted", ack, 1);
    rbyte(v, 1'b1);
    chk(v == model[3], "R8 start abort keeps register", v, model[3]);
    bus_stop();

    // R7: disabled interface
    mode_en = 1'b0;
    write_reg(0, 8'hC3, 1'b0, "R7 no ack when disabled");
    chk(creg(0) == model[0], "R7 no write when disabled", creg(0), model[0]);
    mode_en = 1'b1;
    q(2);

    // R9: second reset clears state
    rst_n = 1'b0; repeat (5) @(negedge clk); rst_n = 1'b1; repeat (10) @(negedge clk);
    chk(cfg == '0, "R9 registers zero after second reset", int'(cfg[31:0]), 0);
    bus_start();
    wbyte(dev(pins, 1'b1), ack); rbyte(v, 1'b1);
    chk(v == 8'h00, "R9 pointer and data zero", v, 0);
    bus_stop();

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule